// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. A processor sees it as two byte-wide registers on a simple write/read bus. Address 0 is a control and status register, and address 1 is a read-only result register. The block divides the system clock by twelve to pace the conversion. For each bit it drives a trial code to an external DAC and samples a single comparator output. It builds the code from the most significant bit down.

Once all eight bits are decided, the finished code goes into the result register. An end-of-conversion flag rises and, if enabled, a level interrupt is raised. A power-enable bit switches the analog part on and off, and it is also brought out on a pin. Every conversion is started by its own write. A start write during a running conversion throws that conversion away and begins again from the top bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 40h (flag set, interrupt enable clear, power clear), the result register reads 00h, `irq` is 0 and `dac_code` is 00h.
- R2: Control register fields: bit 7 interrupt enable (read/write), bit 6 end-of-conversion flag (read-only), bit 5 start (write-only, always reads 0), bit 4 power enable (read/write), bits 3..0 read 0. Address 0 selects control and address 1 selects the result. Writes to address 1 are ignored.
- R3: A control write with bit 5 = 1 and bit 4 = 1, made while power is already on, clears the flag in that same write and starts a conversion. On the following cycle `dac_code` is 80h.
- R4: Each bit takes 12 clock cycles. The comparator is sampled on the last cycle of the period. The bit under trial is kept when `cmp_ge` = 1 and cleared otherwise, and the next lower bit is then set for its trial. With an ideal comparator (`cmp_ge` = input >= `dac_code`), the final code equals the input level.
- R5: The result register and the flag change at the 96th rising edge after the edge that accepted the start. The flag reads 0 at every earlier edge, and the result register keeps its old value until then.
- R6: A start accepted during a conversion abandons it. Trial begins again at 80h, and only the new conversion completes, 96 edges after the restart.
- R7: `irq` is high exactly while both the flag and interrupt enable are 1. Setting the enable while the flag is already 1 raises `irq`.
- R8: While power is off, a start write is ignored: the flag is unchanged and no conversion runs. Clearing power during a conversion stops it, leaves the flag at 0 and leaves the result unchanged.
- R9: If a start is accepted on the same edge where a conversion would finish, the start wins. The finished code is dropped, the flag stays 0, and the new conversion runs in full.
- R10: When a conversion ends, `dac_code` holds its last value and nothing further happens until the next start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 control, 1 result |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| dac_code | output | 8 | Trial code to the external DAC |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| adc_pwr | output | 1 | Analog power enable |
| irq | output | 1 | End-of-conversion interrupt request (level) |

## Verification
Two events can land on one clock edge: a conversion deciding its last bit, and a start write from the processor. The bench counts the cycles from one start and places a second start write on exactly the 96th edge, so that both events coincide. It then judges the outcome at the register interface. The flag must still read 0, the result must still hold the code from the conversion before, and the scoreboard must receive exactly one completion, carrying the second conversion's code, 96 cycles later. A power-off write in the middle of a conversion is judged the same way: the result is unchanged and no completion arrives.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int REG_W = 8;

    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_RESULT = 1'b1;

    localparam int BIT_IE    = 7;
    localparam int BIT_EOC   = 6;
    localparam int BIT_START = 5;
    localparam int BIT_PWR   = 4;

    typedef struct packed {
        logic ie;
        logic eoc;
        logic pwr;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ie: 1'b0, eoc: 1'b1, pwr: 1'b0};

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (restart || !run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick = run && !restart && (s_q.cnt == LAST);

    // R4: a period lasts more than one cycle, so ticks never come back to back
    p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         halt,
    input  logic         tick,
    input  logic         cmp_ge,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] trial,
    output logic [W-1:0] code_out
);

    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);
    localparam logic [W-1:0] TOP_CODE = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     trial;
    } seq_t;

    seq_t s_q, s_d;
    logic [W-1:0] decided;
    logic [IDX_W-1:0] idx_dn;

    always_comb begin
        decided = s_q.trial;
        if (!cmp_ge) begin
            decided[s_q.idx] = 1'b0;
        end
        idx_dn = s_q.idx - 1'b1;

        s_d = s_q;
        if (halt) begin
            s_d.busy = 1'b0;
        end else if (go) begin
            s_d.busy  = 1'b1;
            s_d.idx   = TOP_IDX;
            s_d.trial = TOP_CODE;
        end else if (s_q.busy && tick) begin
            s_d.trial = decided;
            if (s_q.idx == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.idx = idx_dn;
                s_d.trial[idx_dn] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign trial    = s_q.trial;
    assign done     = s_q.busy && tick && (s_q.idx == '0);
    assign code_out = decided;

    // R3/R4: every accepted start puts the top bit alone on the DAC
    p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !halt) |=> (trial == TOP_CODE) && busy);

    // R10: an idle sequencer leaves the DAC code alone
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(trial));

    // R5: leaving busy happens only through completion or a halt
    p_end_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(done) || $past(halt)));

endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_adc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             conv_done,
    input  logic [REG_W-1:0] conv_code,
    output logic             start_acc,
    output logic             pwr_drop,
    output logic             eoc,
    output logic             pwr,
    output logic             irq
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [REG_W-1:0] result;
    } regs_t;

    regs_t s_q, s_d;
    logic  ctrl_wr;
    logic  done_ok;

    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
        start_acc = ctrl_wr && s_q.ctrl.pwr && bus_wdata[BIT_PWR] && bus_wdata[BIT_START];
        pwr_drop  = ctrl_wr && s_q.ctrl.pwr && !bus_wdata[BIT_PWR];
        done_ok   = conv_done && !start_acc && !pwr_drop;

        s_d = s_q;
        if (ctrl_wr) begin
            s_d.ctrl.ie  = bus_wdata[BIT_IE];
            s_d.ctrl.pwr = bus_wdata[BIT_PWR];
        end
        if (start_acc) begin
            s_d.ctrl.eoc = 1'b0;
        end else if (done_ok) begin
            s_d.ctrl.eoc = 1'b1;
            s_d.result   = conv_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl   <= CTRL_RESET;
            s_q.result <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_RESULT) begin
            bus_rdata = s_q.result;
        end else begin
            bus_rdata[BIT_IE]  = s_q.ctrl.ie;
            bus_rdata[BIT_EOC] = s_q.ctrl.eoc;
            bus_rdata[BIT_PWR] = s_q.ctrl.pwr;
        end
    end

    assign eoc = s_q.ctrl.eoc;
    assign pwr = s_q.ctrl.pwr;
    assign irq = s_q.ctrl.eoc && s_q.ctrl.ie;

    // R5: the result register moves only on a completion
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(s_q.result));

    // R5: an undisturbed completion raises the flag
    p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !bus_wr) |=> eoc);

    // R9: a start on the finishing edge keeps the flag low
    p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && start_acc) |=> !eoc && $stable(s_q.result));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int CLK_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic [REG_W-1:0] dac_code,
    input  logic             cmp_ge,
    output logic             adc_pwr,
    output logic             irq
);

    logic             start_acc;
    logic             pwr_drop;
    logic             eoc;
    logic             busy;
    logic             tick;
    logic             conv_done;
    logic [REG_W-1:0] conv_code;

    sar_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .conv_done (conv_done),
        .conv_code (conv_code),
        .start_acc (start_acc),
        .pwr_drop  (pwr_drop),
        .eoc       (eoc),
        .pwr       (adc_pwr),
        .irq       (irq)
    );

    sar_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (start_acc),
        .tick    (tick)
    );

    sar_seq #(.W(REG_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (start_acc),
        .halt     (pwr_drop),
        .tick     (tick),
        .cmp_ge   (cmp_ge),
        .busy     (busy),
        .done     (conv_done),
        .trial    (dac_code),
        .code_out (conv_code)
    );

    // R3: an accepted start clears the flag and runs at once
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !eoc && busy);

    // R8: with power off the sequencer is idle
    p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_pwr |-> !busy);

    // R5: the flag stays low while a conversion runs
    p_busy_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !eoc);

endmodule

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 12;
    localparam int CONV       = 8 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] dac_code;
    logic       cmp_ge;
    logic       adc_pwr;
    logic       irq;
    logic [7:0] vin = '0;

    int total = 0;
    int bad   = 0;
    logic [7:0] expq[$];
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_ge = (vin >= dac_code);

    sar_adc_ctrl #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_code(dac_code),
        .cmp_ge(cmp_ge), .adc_pwr(adc_pwr), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; sampled at the next rising edge
    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 1'b1;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 1'b1;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: start a conversion whose completion the monitor must see
    task automatic run_conv(input logic [7:0] level);
        vin = level;
        bus_write(1'b0, 8'hB0);
        expq.push_back(level);
        wait_neg(CONV + 4);
    endtask

    // monitor: every rising irq is one completion; compare the result
    initial begin : monitor
        logic prev_irq;
        prev_irq = 1'b0;
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                if (irq && !prev_irq) begin
                    if (expq.size() == 0) begin
                        total++; bad++;
                        $display("FAIL R5: actual=completion expected=none at %0t", $time);
                    end else begin
                        check("R4 result", bus_rdata, expq.pop_front());
                    end
                end
                prev_irq = irq;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] v;
        logic [7:0] levels [6];
        levels = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hA5};

        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 layout
        bus_read(1'b0, v); check("R1 ctrl", v, 8'h40);
        bus_read(1'b1, v); check("R1 result", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 dac", dac_code, 8'h00);

        // R8: start with power off is ignored
        @(negedge clk);
        vin = 8'h3C;
        bus_write(1'b0, 8'h20);
        wait_neg(CONV + 4);
        bus_read(1'b0, v); check("R8 ctrl unpowered", v, 8'h40);
        check("R8 dac idle", dac_code, 8'h00);

        // R2: power on, result address not writable
        bus_write(1'b0, 8'h10);
        bus_read(1'b0, v); check("R2 ctrl power", v, 8'h50);
        check("R2 adc_pwr", {7'd0, adc_pwr}, 8'h01);
        @(negedge clk);
        bus_write(1'b1, 8'hEE);
        bus_read(1'b1, v); check("R2 result read-only", v, 8'h00);

        // R3/R4/R5/R7: one conversion timed edge by edge
        @(negedge clk);
        vin = 8'h5A;
        bus_write(1'b0, 8'hB0);
        expq.push_back(8'h5A);
        check("R3 dac msb", dac_code, 8'h80);
        bus_read(1'b0, v); check("R3 flag cleared, R2 start reads 0", v, 8'h90);
        wait_neg(11);
        check("R4 trial held for period", dac_code, 8'h80);
        wait_neg(1);
        check("R4 second trial", dac_code, 8'h40);
        wait_neg(CONV - 1 - 12);
        bus_read(1'b0, v); check("R5 flag low before end", v, 8'h90);
        bus_read(1'b1, v); check("R5 result held", v, 8'h00);
        wait_neg(1);
        bus_read(1'b0, v); check("R5 flag at end", v, 8'hD0);
        bus_read(1'b1, v); check("R5 result", v, 8'h5A);
        check("R7 irq", {7'd0, irq}, 8'h01);

        // R10: no activity after completion
        for (int i = 0; i < CONV + 4; i++) begin
            @(negedge clk);
            if (dac_code !== 8'h5A) check("R10 dac stable", dac_code, 8'h5A);
        end
        check("R10 dac final", dac_code, 8'h5A);

        // R4: several levels through the scoreboard
        foreach (levels[k]) run_conv(levels[k]);

        // R6: restart mid-conversion
        vin = 8'h33;
        bus_write(1'b0, 8'hB0);
        wait_neg(40);
        vin = 8'hC4;
        bus_write(1'b0, 8'hB0);
        expq.push_back(8'hC4);
        check("R6 restart from msb", dac_code, 8'h80);
        wait_neg(CONV + 4);
        bus_read(1'b1, v); check("R6 restarted result", v, 8'hC4);

        // R9: start on the finishing edge
        vin = 8'h11;
        bus_write(1'b0, 8'hB0);
        wait_neg(CONV - 1);
        vin = 8'h77;
        bus_write(1'b0, 8'hB0);
        expq.push_back(8'h77);
        bus_read(1'b0, v); check("R9 flag stays low", v, 8'h90);
        bus_read(1'b1, v); check("R9 result unchanged", v, 8'hC4);
        wait_neg(CONV + 4);
        bus_read(1'b1, v); check("R9 second result", v, 8'h77);

        // R7: masked completion, then enable raises irq
        vin = 8'h42;
        bus_write(1'b0, 8'h30);
        wait_neg(CONV + 4);
        check("R7 masked irq", {7'd0, irq}, 8'h00);
        bus_read(1'b0, v); check("R7 flag set masked", v, 8'h50);
        expq.push_back(8'h42);
        bus_write(1'b0, 8'h90);
        wait_neg(2);
        check("R7 irq after enable", {7'd0, irq}, 8'h01);

        // R8: power off mid-conversion
        vin = 8'h99;
        bus_write(1'b0, 8'hB0);
        wait_neg(30);
        bus_write(1'b0, 8'h80);
        wait_neg(CONV + 4);
        bus_read(1'b0, v); check("R8 stopped ctrl", v, 8'h80);
        bus_read(1'b1, v); check("R8 result unchanged", v, 8'h42);
        check("R8 irq", {7'd0, irq}, 8'h00);
        check("R8 adc_pwr", {7'd0, adc_pwr}, 8'h00);

        wait_neg(4);
        check("R5 scoreboard drained", 8'(expq.size()), 8'h00);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule